// File: doc/BRIEF.md
# Mirrored Address Window Mapper

This block sits between the data port of a processor core and a byte-addressed memory space of 1 MB. It resolves every request address in the cycle the request arrives. A programmable window near the top of the space is redirected onto a region of low code memory. One bank-select input chooses which 64 KB code bank the window lands in. Instruction fetches bypass the window entirely, so code cannot execute from the mirror.

Data reads that land in the window are slower than other accesses. The mapper reports a mirror flag and a wait count alongside the translated address. It then holds `ready` low for that many cycles before the read completes. Two regions give fixed filler bytes instead of memory data: fetches from unimplemented code space, and data reads of the peripheral-register hole that no peripheral claims.

The window base, window length, code base and code-space limit sit in registers. These are written through a small configuration port, which takes effect only while the mapper is idle.

Top module: `mirror_window_mapper`

## Requirements
- R1: Only the low 20 bits of `req_addr` are used; bits 23:20 have no effect on any output.
- R2: After reset the window covers 0xF1000 up to 0xF7FFF, maps onto code address 0x01000, and the code-space limit is 0x100000.
- R3: A data access (read or write) whose masked address A satisfies base <= A < base+length drives `mem_addr` = A - base + code base (modulo 2^20) and raises `mirror_hit`; addresses one below the base or equal to base+length do not hit.
- R4: When `bank_sel` is 1, a window hit additionally forces bit 16 of `mem_addr` to 1.
- R5: A data access outside the window drives `mem_addr` with the masked address unchanged and keeps `mirror_hit` low.
- R6: An instruction fetch (`req_fetch`=1) is never redirected: `mem_addr` is the masked address and `mirror_hit` stays low, even inside the window.
- R7: A data read that hits the window shows `wait_cnt`=3 and holds `ready` low for exactly 3 cycles, starting with its arrival cycle, and `ready` rises in the 4th cycle. Every other request shows `wait_cnt`=0 and `ready` high in its arrival cycle.
- R8: A data write through the window is translated like a read but shows `wait_cnt`=0 and `ready` high in its arrival cycle.
- R9: A fetch whose masked address is at or above the code-space limit and below 0xF0000 returns 0xFF on `rd_data`; other fetches return `mem_rdata`.
- R10: A data read whose translated address lies in 0xF0000 to 0xF0FFF returns 0x11 when `periph_claim` is 0 and returns `mem_rdata` when it is 1.
- R11: A configuration write is taken only in a cycle with `req_valid` low while no wait is in progress; otherwise it is ignored. The select codes are 0 window base, 1 window length, 2 code base and 3 code limit. The limit uses all 21 bits of `cfg_wdata`, and the other three use bits 19:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 21 | Configuration write value |
| bank_sel | input | 1 | Bank-select control bit for the window |
| req_valid | input | 1 | Request present |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| req_write | input | 1 | 1 for data write, 0 for read |
| req_addr | input | 24 | Request address before masking |
| periph_claim | input | 1 | A peripheral register claims the current hole address |
| mem_rdata | input | 8 | Byte returned by the memory arrays |
| mem_addr | output | 20 | Translated memory address |
| mirror_hit | output | 1 | Request resolved through the window |
| wait_cnt | output | 2 | Wait cycles added to this request |
| rd_data | output | 8 | Read byte after filler substitution |
| ready | output | 1 | Request completes in this cycle |

## Verification
The assertions assume that the core holds `req_valid`, the address and the request kind stable from the arrival of a request until `ready` is seen high. They also assume it raises no write or fetch in the middle of a windowed read's wait. The bench meets this by driving one request per task call on the falling edge and keeping it until `ready` rises. It drops or replaces the request only on the falling edge after completion. Random addresses are drawn mostly near the window edges, the peripheral hole and the code limit, with the bank bit, the claim input and the request kind all drawn at random. Directed cases cover reprogramming the window and configuration writes that must be ignored.

// File: rtl/amap_pkg.sv
package amap_pkg;

  typedef enum logic [1:0] {
    CFG_WIN_BASE   = 2'd0,
    CFG_WIN_LEN    = 2'd1,
    CFG_CODE_BASE  = 2'd2,
    CFG_CODE_LIMIT = 2'd3
  } cfg_sel_e;

  typedef enum logic {
    WST_IDLE = 1'b0,
    WST_WAIT = 1'b1
  } wait_state_e;

  localparam int unsigned DEF_WIN_BASE   = 32'h000F_1000;
  localparam int unsigned DEF_WIN_LEN    = 32'h0000_7000;
  localparam int unsigned DEF_CODE_BASE  = 32'h0000_1000;
  localparam int unsigned DEF_CODE_LIMIT = 32'h0010_0000;

  localparam int unsigned HOLE_BASE  = 32'h000F_0000;
  localparam int unsigned HOLE_SIZE  = 32'h0000_1000;
  localparam int unsigned FETCH_TOP  = 32'h000F_0000;

  localparam logic [7:0] FILL_FETCH = 8'hFF;
  localparam logic [7:0] FILL_HOLE  = 8'h11;

endpackage

// File: rtl/amap_cfg_regs.sv
module amap_cfg_regs
  import amap_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  cfg_sel_e      sel,
  input  logic [AW:0]   wdata,
  output logic [AW-1:0] win_base,
  output logic [AW:0]   win_len,
  output logic [AW-1:0] code_base,
  output logic [AW:0]   code_limit
);

  logic [AW-1:0] win_base_q,  win_base_d;
  logic [AW:0]   win_len_q,   win_len_d;
  logic [AW-1:0] code_base_q, code_base_d;
  logic [AW:0]   code_lim_q,  code_lim_d;

  always_comb begin
    win_base_d  = win_base_q;
    win_len_d   = win_len_q;
    code_base_d = code_base_q;
    code_lim_d  = code_lim_q;
    case (sel)
      CFG_WIN_BASE:   win_base_d  = wdata[AW-1:0];
      CFG_WIN_LEN:    win_len_d   = {1'b0, wdata[AW-1:0]};
      CFG_CODE_BASE:  code_base_d = wdata[AW-1:0];
      CFG_CODE_LIMIT: code_lim_d  = wdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base_q  <= AW'(DEF_WIN_BASE);
      win_len_q   <= (AW+1)'(DEF_WIN_LEN);
      code_base_q <= AW'(DEF_CODE_BASE);
      code_lim_q  <= (AW+1)'(DEF_CODE_LIMIT);
    end else if (wr_en) begin
      win_base_q  <= win_base_d;
      win_len_q   <= win_len_d;
      code_base_q <= code_base_d;
      code_lim_q  <= code_lim_d;
    end
  end

  assign win_base   = win_base_q;
  assign win_len    = win_len_q;
  assign code_base  = code_base_q;
  assign code_limit = code_lim_q;

endmodule

// File: rtl/amap_xlate.sv
module amap_xlate
  import amap_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int BANK_BIT = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          fetch,
  input  logic          write,
  input  logic          bank_sel,
  input  logic          periph_claim,
  input  logic [AW-1:0] win_base,
  input  logic [AW:0]   win_len,
  input  logic [AW-1:0] code_base,
  input  logic [AW:0]   code_limit,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          hit,
  output logic [DW-1:0] rd_data
);

  localparam int EW = AW + 2;
  localparam logic [EW-1:0] HOLE_LO  = EW'(HOLE_BASE);
  localparam logic [EW-1:0] HOLE_HI  = EW'(HOLE_BASE + HOLE_SIZE);
  localparam logic [EW-1:0] FETCH_HI = EW'(FETCH_TOP);

  logic [EW-1:0] addr_x, base_x, end_x, lim_x, mapped_x;
  logic [AW-1:0] offset, moved;
  logic          in_win, fetch_fill, hole_fill;

  always_comb begin
    addr_x = EW'(addr);
    base_x = EW'(win_base);
    end_x  = base_x + EW'(win_len);
    lim_x  = EW'(code_limit);

    in_win = !fetch && (addr_x >= base_x) && (addr_x < end_x);

    offset = addr - win_base;
    moved  = offset + code_base;
    if (bank_sel) moved[BANK_BIT] = 1'b1;

    mem_addr = in_win ? moved : addr;
    hit      = in_win;

    mapped_x   = EW'(mem_addr);
    fetch_fill = fetch && (addr_x >= lim_x) && (addr_x < FETCH_HI);
    hole_fill  = !fetch && !write && !periph_claim &&
                 (mapped_x >= HOLE_LO) && (mapped_x < HOLE_HI);

    if (fetch_fill)     rd_data = DW'(FILL_FETCH);
    else if (hole_fill) rd_data = DW'(FILL_HOLE);
    else                rd_data = mem_rdata;
  end

endmodule

// File: rtl/amap_wait.sv
module amap_wait
  import amap_pkg::*;
#(
  parameter int WAIT_CLKS = 3,
  parameter int CW        = $clog2(WAIT_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic need_wait,
  output logic ready,
  output logic idle
);

  wait_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start, step;

  assign start = req_valid && need_wait;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ready = 1'b1;
    case (st_q)
      WST_IDLE: begin
        ready = !start;
        if (start) begin
          st_d  = WST_WAIT;
          cnt_d = CW'(WAIT_CLKS - 1);
        end
      end
      WST_WAIT: begin
        ready = (cnt_q == '0);
        if (cnt_q == '0) st_d  = WST_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = WST_IDLE;
    endcase
  end

  assign step = (st_q == WST_WAIT) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WST_IDLE;
      cnt_q <= '0;
    end else if (step) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle = (st_q == WST_IDLE);

endmodule

// File: rtl/mirror_window_mapper.sv
module mirror_window_mapper
  import amap_pkg::*;
#(
  parameter int AIN       = 24,
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int WAIT_CLKS = 3,
  parameter int BANK_BIT  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [1:0]                     cfg_sel,
  input  logic [AW:0]                    cfg_wdata,
  input  logic                           bank_sel,
  input  logic                           req_valid,
  input  logic                           req_fetch,
  input  logic                           req_write,
  input  logic [AIN-1:0]                 req_addr,
  input  logic                           periph_claim,
  input  logic [DW-1:0]                  mem_rdata,
  output logic [AW-1:0]                  mem_addr,
  output logic                           mirror_hit,
  output logic [$clog2(WAIT_CLKS+1)-1:0] wait_cnt,
  output logic [DW-1:0]                  rd_data,
  output logic                           ready
);

  localparam int WCW = $clog2(WAIT_CLKS + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] addr_m;
  logic          unused_hi;
  logic [AW-1:0] win_base, code_base;
  logic [AW:0]   win_len, code_limit;
  logic          hit, mirror_rd, idle, cfg_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  generate
    if (AIN > AW) begin : g_mask
      assign addr_m    = req_addr[AW-1:0];
      assign unused_hi = ^req_addr[AIN-1:AW];
    end else begin : g_nomask
      assign addr_m    = AW'(req_addr);
      assign unused_hi = 1'b0;
    end
  endgenerate

  assign cfg_take = cfg_we && idle && !req_valid;

  amap_cfg_regs #(.AW(AW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (cfg_take),
    .sel        (cfg_sel_e'(cfg_sel)),
    .wdata      (cfg_wdata),
    .win_base   (win_base),
    .win_len    (win_len),
    .code_base  (code_base),
    .code_limit (code_limit)
  );

  amap_xlate #(.AW(AW), .DW(DW), .BANK_BIT(BANK_BIT)) u_xlate (
    .addr         (addr_m),
    .fetch        (req_fetch),
    .write        (req_write),
    .bank_sel     (bank_sel),
    .periph_claim (periph_claim),
    .win_base     (win_base),
    .win_len      (win_len),
    .code_base    (code_base),
    .code_limit   (code_limit),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .hit          (hit),
    .rd_data      (rd_data)
  );

  assign mirror_rd = hit && !req_write;

  amap_wait #(.WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .need_wait (mirror_rd),
    .ready     (ready),
    .idle      (idle)
  );

  assign mirror_hit = hit;
  assign wait_cnt   = mirror_rd ? WCW'(WAIT_CLKS) : '0;

endmodule

// File: rtl/mirror_window_mapper_chk.sv
module mirror_window_mapper_chk
  import amap_pkg::*;
#(
  parameter int AIN       = 24,
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int WAIT_CLKS = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic                           req_fetch,
  input logic                           req_write,
  input logic                           periph_claim,
  input logic [AW-1:0]                  mem_addr,
  input logic                           mirror_hit,
  input logic [$clog2(WAIT_CLKS+1)-1:0] wait_cnt,
  input logic [DW-1:0]                  rd_data,
  input logic                           ready
);

  localparam int LW = $clog2(WAIT_CLKS + 2);
  localparam logic [AW:0] HOLE_LO = (AW+1)'(HOLE_BASE);
  localparam logic [AW:0] HOLE_HI = (AW+1)'(HOLE_BASE + HOLE_SIZE);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            low_run <= '0;
    else if (ready)                        low_run <= '0;
    else if (low_run != LW'(WAIT_CLKS+1))  low_run <= low_run + 1'b1;
  end

  // R6
  fetch_not_mirrored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_fetch |-> !mirror_hit);

  // R7
  low_run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (low_run < LW'(WAIT_CLKS)));

  // R7
  wait_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ready && (wait_cnt != '0) |-> (low_run == LW'(WAIT_CLKS)));

  // R7
  plain_access_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mirror_hit |-> ready);

  // R8
  write_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> ready && (wait_cnt == '0));

  // R10
  hole_filler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_fetch && !req_write && !periph_claim &&
    ({1'b0, mem_addr} >= HOLE_LO) && ({1'b0, mem_addr} < HOLE_HI)
    |-> rd_data == DW'(FILL_HOLE));

endmodule

bind mirror_window_mapper mirror_window_mapper_chk #(
  .AIN(AIN), .AW(AW), .DW(DW), .WAIT_CLKS(WAIT_CLKS)
) u_chk (.*);

// File: tb/mirror_window_mapper_test.sv
`timescale 1ns/1ps
module mirror_window_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [20:0] cfg_wdata;
  logic        bank_sel, req_valid, req_fetch, req_write, periph_claim;
  logic [23:0] req_addr;
  logic [7:0]  mem_rdata;
  logic [19:0] mem_addr;
  logic        mirror_hit;
  logic [1:0]  wait_cnt;
  logic [7:0]  rd_data;
  logic        ready;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned m_base = 32'hF1000, m_len = 32'h7000, m_code = 32'h1000, m_lim = 32'h100000;

  always #2.5 clk = ~clk;

  mirror_window_mapper uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bank_sel(bank_sel), .req_valid(req_valid), .req_fetch(req_fetch), .req_write(req_write),
    .req_addr(req_addr), .periph_claim(periph_claim), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mirror_hit(mirror_hit), .wait_cnt(wait_cnt), .rd_data(rd_data),
    .ready(ready)
  );

  task automatic check(input string req, input string what, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned exp_map(input int unsigned a, input bit fetch, input bit bank, output bit hit);
    int unsigned m = a & 32'hFFFFF;
    int unsigned t;
    hit = !fetch && (m >= m_base) && (m < m_base + m_len);
    if (!hit) return m;
    t = (m - m_base + m_code) & 32'hFFFFF;
    if (bank) t = t | 32'h10000;
    return t;
  endfunction

  function automatic int unsigned exp_rd(input int unsigned a, input int unsigned t, input bit fetch,
                                         input bit wr, input bit claim, input int unsigned rdat);
    int unsigned m = a & 32'hFFFFF;
    if (fetch && m >= m_lim && m < 32'hF0000) return 32'hFF;
    if (!fetch && !wr && !claim && t >= 32'hF0000 && t < 32'hF1000) return 32'h11;
    return rdat;
  endfunction

  task automatic access(input string req, input int unsigned a, input bit fetch, input bit wr,
                        input bit claim, input bit bank);
    bit hit;
    int unsigned t, rdat, waits, lows;
    rdat = $urandom_range(0, 255);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a[23:0]; req_fetch = fetch; req_write = wr;
    periph_claim = claim; bank_sel = bank; mem_rdata = rdat[7:0];
    #1;
    t = exp_map(a, fetch, bank, hit);
    waits = (hit && !wr) ? 3 : 0;
    check(req, "mem_addr", mem_addr, t);
    check(req, "mirror_hit", mirror_hit, hit);
    check(req, "wait_cnt", wait_cnt, waits);
    check(req, "rd_data", rd_data, exp_rd(a, t, fetch, wr, claim, rdat));
    lows = 0;
    while (!ready && lows < 10) begin
      lows++;
      @(negedge clk); #1;
    end
    check(req, "ready_low_cycles", lows, waits);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_write(input int unsigned sel, input int unsigned val);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val[20:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_base = val & 32'hFFFFF;
      1: m_len  = val & 32'hFFFFF;
      2: m_code = val & 32'hFFFFF;
      default: m_lim = val & 32'h1FFFFF;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v, a, kind;
    bit f, w;
    seed_v = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0; bank_sel = 1'b0;
    req_valid = 1'b0; req_fetch = 1'b0; req_write = 1'b0; req_addr = '0;
    periph_claim = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R7", "reset_ready", ready, 1);
    check("R2", "reset_mirror_hit", mirror_hit, 0);

    // R2 / R3 default window edges
    access("R2", 32'hF1000, 0, 0, 0, 0);
    access("R3", 32'hF7FFF, 0, 0, 0, 0);
    access("R3", 32'hF8000, 0, 0, 0, 0);
    access("R3", 32'hF0FFF, 0, 0, 1, 0);
    access("R5", 32'h0EFFF, 0, 0, 0, 0);
    access("R1", 32'hABF1234, 0, 0, 0, 0);
    access("R1", 32'h5F8000, 0, 0, 0, 0);
    access("R4", 32'hF1000, 0, 0, 0, 1);
    access("R4", 32'hF5ABC, 0, 0, 0, 1);
    access("R6", 32'hF1000, 1, 0, 0, 0);
    access("R8", 32'hF2000, 0, 1, 0, 0);
    access("R10", 32'hF0123, 0, 0, 0, 0);
    access("R10", 32'hF0123, 0, 0, 1, 0);
    access("R9", 32'hEFFFF, 1, 0, 0, 0);

    // R11 config write during a windowed read must be ignored
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 21'h10000;
    access("R11", 32'hF1000, 0, 0, 0, 0);
    access("R11", 32'hF2000, 1, 0, 0, 0);
    idle_cycle();
    access("R11", 32'hF1000, 0, 0, 0, 0);

    // R11 / R9 reprogramming takes effect when idle
    cfg_write(0, 32'hE8000);
    cfg_write(1, 32'h00800);
    cfg_write(2, 32'h20000);
    cfg_write(3, 32'h40000);
    access("R11", 32'hE8000, 0, 0, 0, 0);
    access("R3", 32'hE87FF, 0, 0, 0, 0);
    access("R3", 32'hE8800, 0, 0, 0, 0);
    access("R3", 32'hE7FFF, 0, 0, 0, 0);
    access("R9", 32'h40000, 1, 0, 0, 0);
    access("R9", 32'h3FFFF, 1, 0, 0, 0);
    access("R9", 32'hEFFFF, 1, 0, 0, 0);
    access("R9", 32'hF0000, 1, 0, 0, 0);

    // R10 window placed over the hole via translation
    cfg_write(2, 32'hF0000);
    access("R10", 32'hE8010, 0, 0, 0, 0);
    access("R10", 32'hE8010, 0, 0, 1, 0);

    // random mix checked against the model
    for (int i = 0; i < 400; i++) begin
      if (i == 200) begin
        cfg_write(0, 32'hF1000); cfg_write(1, 32'h7000);
        cfg_write(2, 32'h1000);  cfg_write(3, 32'h30000);
      end
      kind = $urandom_range(0, 4);
      case (kind)
        0: a = m_base + $urandom_range(0, m_len - 1);
        1: a = m_base + m_len - 2 + $urandom_range(0, 3);
        2: a = 32'hF0000 + $urandom_range(0, 32'hFFF);
        3: a = m_lim - 2 + $urandom_range(0, 3);
        default: a = $urandom_range(0, 32'hFFFFFF);
      endcase
      a = a | ($urandom_range(0, 15) << 20);
      f = ($urandom_range(0, 3) == 0);
      w = !f && ($urandom_range(0, 4) == 0);
      access("R3/R7/R9/R10", a, f, w, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    idle_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule